// File: doc/BRIEF.md
# Block Floating Point to Fixed Point Aligner

This block sits after a transform engine that emits complex samples in block floating point form: each packet carries one exponent and a run of real and imaginary mantissas of fixed width. Packets processed one after another may carry different exponents, so their mantissas do not share a radix point. The aligner puts every packet on a common scale by shifting its mantissas right by the packet exponent minus a reference exponent. The reference exponent is a static configuration input that the block reads and never derives from the data.

The shift never goes left, because the mantissas already use their full range and a left shift could overflow. Only a small, power-of-two count of shift values is supported. The result is picked by a multiplexer from precomputed copies of the input shifted by 0, 1, 2 and further places, so no general barrel shifter is built. A difference below zero or above the largest supported shift is clamped, and a sticky flag records that this happened. The stream uses ready/valid with start and end of packet markers. Backpressure passes straight through and the data path has one register stage.

Top module: `bfp_to_fixed_align`

## Requirements
- R1: For a packet with exponent E and reference exponent F, with E − F in 0 .. NUM_SHIFTS−1, every real and imaginary output equals the matching input, read as two's complement, divided by 2^(E−F) and rounded toward negative infinity (arithmetic right shift with sign fill). The output width equals the input width.
- R2: When E − F is negative, the packet passes with shift 0, so the outputs equal the inputs, and the sticky flag `clamp_seen` is set.
- R3: When E − F exceeds NUM_SHIFTS−1, the packet is shifted by NUM_SHIFTS−1 and `clamp_seen` is set.
- R4: The exponent and the reference are sampled only on an accepted beat that has `in_sop` high. Every later beat up to the next start of packet uses that shift, whatever `in_exp` holds. Beats accepted after reset and before any start of packet use shift 0.
- R5: A beat accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the next edge with `out_valid` high and with `out_sop` and `out_eop` equal to its `in_sop` and `in_eop`.
- R6: `in_ready` always equals `out_ready`. While `out_ready` is low, `out_valid`, `out_sop`, `out_eop`, `out_re` and `out_im` hold their values.
- R7: `clamp_seen` stays high once set and is cleared only by reset. Packets that need no clamping leave it low.
- R8: Synchronous active-high reset drives `out_valid`, `out_sop`, `out_eop`, `out_re`, `out_im` and `clamp_seen` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_exp | input | EXP_W | Signed reference exponent, static configuration |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input may be accepted (equals out_ready) |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_exp | input | EXP_W | Signed packet exponent, sampled with in_sop |
| in_re | input | DATA_W | Signed real mantissa |
| in_im | input | DATA_W | Signed imaginary mantissa |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_sop | output | 1 | First beat of an aligned packet |
| out_eop | output | 1 | Last beat of an aligned packet |
| out_re | output | DATA_W | Aligned real sample |
| out_im | output | DATA_W | Aligned imaginary sample |
| clamp_seen | output | 1 | Sticky flag set when a difference was clamped |

## Verification
A wrong shift held between packets shows on the very next beat. Every beat after a start of packet is exposed one cycle after it is accepted, because each non-start beat carries a deliberately different exponent that must be ignored. A clamp decision taken on the wrong side appears either as an output that differs from the exact floor division or as a `clamp_seen` value that disagrees with the packet just sent. A stage that fails to stall shows at once: its outputs change during the single cycle in which `out_ready` is held low.

// File: rtl/bfp_align_pkg.sv
package bfp_align_pkg;

    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
    } beat_ctl_t;

    typedef struct packed {
        logic [7:0] amount;
        logic       clipped;
    } shift_pick_t;

    function automatic shift_pick_t pick_shift(input int diff, input int max_shift);
        shift_pick_t r;
        if (diff < 0) begin
            r.amount  = 8'd0;
            r.clipped = 1'b1;
        end else if (diff > max_shift) begin
            r.amount  = 8'(max_shift);
            r.clipped = 1'b1;
        end else begin
            r.amount  = 8'(diff);
            r.clipped = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/bfp_shift_sel.sv
module bfp_shift_sel
    import bfp_align_pkg::*;
#(
    parameter int EXP_W      = 5,
    parameter int NUM_SHIFTS = 4,
    parameter int SEL_W      = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  logic                    sop,
    input  logic signed [EXP_W-1:0] pkt_exp,
    input  logic signed [EXP_W-1:0] ref_exp,
    output logic [SEL_W-1:0]        sel,
    output logic                    clamp_seen
);
    localparam int MAX_SHIFT = NUM_SHIFTS - 1;

    shift_pick_t      pick;
    logic [SEL_W-1:0] held_q;
    int               diff;

    always_comb begin
        diff = int'(pkt_exp) - int'(ref_exp);
        pick = pick_shift(diff, MAX_SHIFT);
        sel  = sop ? pick.amount[SEL_W-1:0] : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= '0;
            clamp_seen <= 1'b0;
        end else if (accept && sop) begin
            held_q     <= pick.amount[SEL_W-1:0];
            clamp_seen <= clamp_seen | pick.clipped;
        end
    end

    // R4: a beat inside a packet must not disturb the held shift
    assert_hold_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !sop) |=> $stable(held_q));

    // R7: the clamp flag is sticky
    assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (rst)
        clamp_seen |=> clamp_seen);

endmodule

// File: rtl/bfp_shift_mux.sv
module bfp_shift_mux #(
    parameter int DATA_W     = 16,
    parameter int NUM_SHIFTS = 4,
    parameter int SEL_W      = 2
) (
    input  logic signed [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]         sel,
    output logic signed [DATA_W-1:0] dout
);
    logic signed [DATA_W-1:0] copies [NUM_SHIFTS];

    for (genvar k = 0; k < NUM_SHIFTS; k++) begin : g_copy
        assign copies[k] = din >>> k;
    end

    assign dout = copies[sel];

endmodule

// File: rtl/bfp_to_fixed_align.sv
module bfp_to_fixed_align
    import bfp_align_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int EXP_W      = 5,
    parameter int NUM_SHIFTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [EXP_W-1:0]  ref_exp,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im,
    output logic                     clamp_seen
);
    localparam int SEL_W = (NUM_SHIFTS > 1) ? $clog2(NUM_SHIFTS) : 1;

    if ((NUM_SHIFTS < 2) || ((NUM_SHIFTS & (NUM_SHIFTS - 1)) != 0)) begin : g_bad_count
        $error("NUM_SHIFTS must be a power of two of at least 2");
    end

    logic                     accept;
    logic [SEL_W-1:0]         sel;
    logic signed [DATA_W-1:0] re_shifted;
    logic signed [DATA_W-1:0] im_shifted;
    beat_ctl_t                ctl_q;

    assign in_ready = out_ready;
    assign accept   = in_valid & out_ready;

    bfp_shift_sel #(
        .EXP_W      (EXP_W),
        .NUM_SHIFTS (NUM_SHIFTS),
        .SEL_W      (SEL_W)
    ) sel_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .sop        (in_sop),
        .pkt_exp    (in_exp),
        .ref_exp    (ref_exp),
        .sel        (sel),
        .clamp_seen (clamp_seen)
    );

    bfp_shift_mux #(.DATA_W(DATA_W), .NUM_SHIFTS(NUM_SHIFTS), .SEL_W(SEL_W)) mux_re_i (
        .din  (in_re),
        .sel  (sel),
        .dout (re_shifted)
    );

    bfp_shift_mux #(.DATA_W(DATA_W), .NUM_SHIFTS(NUM_SHIFTS), .SEL_W(SEL_W)) mux_im_i (
        .din  (in_im),
        .sel  (sel),
        .dout (im_shifted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            out_re <= '0;
            out_im <= '0;
        end else if (out_ready) begin
            ctl_q.valid <= in_valid;
            ctl_q.sop   <= in_valid & in_sop;
            ctl_q.eop   <= in_valid & in_eop;
            out_re      <= re_shifted;
            out_im      <= im_shifted;
        end
    end

    assign out_valid = ctl_q.valid;
    assign out_sop   = ctl_q.sop;
    assign out_eop   = ctl_q.eop;

    // R5: an accepted beat emerges one edge later with its markers
    assert_beat_forward_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && (out_sop == $past(in_sop)) && (out_eop == $past(in_eop))));

    // R6: a stalled output does not move
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> ($stable(out_re) && $stable(out_im) && $stable(out_valid)));

    // R1: a right shift never grows a non-negative sample nor flips its sign
    assert_no_growth_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_re[DATA_W-1]) |=> ((out_re <= $past(in_re)) && !out_re[DATA_W-1]));

    // R1: a negative sample stays negative and does not shrink in value
    assert_sign_kept_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && in_im[DATA_W-1]) |=> (out_im[DATA_W-1] && (out_im >= $past(in_im))));

endmodule

// File: tb/bfp_to_fixed_align_tb.sv
module bfp_to_fixed_align_tb_top;
    localparam int DATA_W     = 16;
    localparam int EXP_W      = 5;
    localparam int NUM_SHIFTS = 4;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic signed [EXP_W-1:0]  ref_exp = '0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic                     in_sop = 1'b0;
    logic                     in_eop = 1'b0;
    logic signed [EXP_W-1:0]  in_exp = '0;
    logic signed [DATA_W-1:0] in_re = '0;
    logic signed [DATA_W-1:0] in_im = '0;
    logic                     out_valid;
    logic                     out_ready = 1'b1;
    logic                     out_sop;
    logic                     out_eop;
    logic signed [DATA_W-1:0] out_re;
    logic signed [DATA_W-1:0] out_im;
    logic                     clamp_seen;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bfp_to_fixed_align #(.DATA_W(DATA_W), .EXP_W(EXP_W), .NUM_SHIFTS(NUM_SHIFTS)) dut_i (
        .clk (clk), .rst (rst), .ref_exp (ref_exp),
        .in_valid (in_valid), .in_ready (in_ready), .in_sop (in_sop), .in_eop (in_eop),
        .in_exp (in_exp), .in_re (in_re), .in_im (in_im),
        .out_valid (out_valid), .out_ready (out_ready), .out_sop (out_sop), .out_eop (out_eop),
        .out_re (out_re), .out_im (out_im), .clamp_seen (clamp_seen)
    );

    function automatic int wrap_w(input int v);
        logic signed [DATA_W-1:0] t;
        t = v[DATA_W-1:0];
        return int'(t);
    endfunction

    function automatic int floor_div(input int x, input int s);
        int p;
        p = 1 << s;
        if (x >= 0) return x / p;
        return -((-x + p - 1) / p);
    endfunction

    function automatic int clamp_amt(input int d);
        if (d < 0) return 0;
        if (d > NUM_SHIFTS - 1) return NUM_SHIFTS - 1;
        return d;
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives one beat at the falling edge and checks it one register later.
    task automatic send_beat(input bit sop, input bit eop, input int e, input int re, input int im,
                             input int sh, input string req);
        int xr;
        int xi;
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop;
        in_exp = e[EXP_W-1:0]; in_re = re[DATA_W-1:0]; in_im = im[DATA_W-1:0];
        xr = floor_div(wrap_w(re), sh);
        xi = floor_div(wrap_w(im), sh);
        @(posedge clk);
        #1;
        check(out_valid && (out_sop == sop) && (out_eop == eop), "R5", "markers",
              {out_valid, out_sop, out_eop}, {1'b1, sop, eop});
        check((int'(out_re) == xr) && (int'(out_im) == xi), req, "data re",
              int'(out_re), xr);
        check(int'(out_im) == xi, req, "data im", int'(out_im), xi);
    endtask

    task automatic go_idle;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 200000);
                report();
            end
        end
    end

    initial begin
        int refs [3] = '{0, 2, -3};
        do_reset();

        // R8: reset state
        #1;
        check(!out_valid && !out_sop && !out_eop, "R8", "ctl after reset", out_valid, 0);
        check(out_re == 0 && out_im == 0, "R8", "data after reset", int'(out_re), 0);
        check(!clamp_seen, "R8", "flag after reset", clamp_seen, 0);

        // R6: ready passes through
        out_ready = 1'b0; #1;
        check(in_ready == 1'b0, "R6", "in_ready low", in_ready, 0);
        out_ready = 1'b1; #1;
        check(in_ready == 1'b1, "R6", "in_ready high", in_ready, 1);

        // R4: a beat before any start of packet uses shift 0, even with a large exponent
        ref_exp = '0;
        send_beat(1'b0, 1'b0, 9, -12345, 4321, 0, "R4");
        go_idle();

        // R1 R2 R3 R4 R7: sweep every exponent against several references
        foreach (refs[ri]) begin
            for (int e = -16; e < 16; e++) begin
                int d;
                int sh;
                bit clipped;
                do_reset();
                ref_exp = refs[ri][EXP_W-1:0];
                d  = e - refs[ri];
                sh = clamp_amt(d);
                clipped = (d < 0) || (d > NUM_SHIFTS - 1);
                send_beat(1'b1, 1'b0, e, e * 1237 + 5, -(e * 2011) - 77,
                          sh, (d < 0) ? "R2" : (clipped ? "R3" : "R1"));
                // R4: mid-packet beats carry a misleading exponent
                send_beat(1'b0, 1'b0, -e - 1, -32768 + e * 3, 32767 - e, sh, "R4");
                send_beat(1'b0, 1'b1, e + 7, -1 - e, e * 999, sh, "R4");
                go_idle();
                #1;
                check(clamp_seen == clipped, clipped ? ((d < 0) ? "R2" : "R3") : "R7",
                      "clamp flag", clamp_seen, clipped);
            end
        end

        // R7: flag stays set across a later clean packet
        do_reset();
        ref_exp = '0;
        send_beat(1'b1, 1'b1, 12, 1000, -1000, 3, "R3");
        send_beat(1'b1, 1'b1, 1, 1000, -1000, 1, "R1");
        go_idle();
        #1;
        check(clamp_seen == 1'b1, "R7", "sticky flag", clamp_seen, 1);

        // R6: stall holds the outputs
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_exp = 5'sd2;
        in_re = -16'sd100; in_im = 16'sd100;
        @(posedge clk); #1;
        check(int'(out_re) == -25 && int'(out_im) == 25, "R1", "pre-stall data", int'(out_re), -25);
        @(negedge clk);
        out_ready = 1'b0; in_re = 16'sd5000; in_im = -16'sd5000; in_exp = '0;
        @(posedge clk); #1;
        check(out_valid && int'(out_re) == -25 && int'(out_im) == 25, "R6", "stall hold",
              int'(out_re), -25);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk); #1;
        check(int'(out_re) == 5000 && int'(out_im) == -5000, "R6", "release", int'(out_re), 5000);
        go_idle();

        report();
    end

endmodule